// File: doc/BRIEF.md
# Masked Interrupt Aggregation Controller

This block merges interrupt requests from many sources into one level-sensitive request line for a processor. It holds a 16-bit pending vector. Sources raise bits with a set strobe vector and lower them with a clear strobe vector. The lower eight pending bits are maskable, and an 8-bit enable register gates them. The upper pending bits ignore the mask and drive the request line whenever any of them is held.

The processor reaches the block through a small register port. Address 0 is the enable register, which can be written and read. Address 1 returns the maskable byte of the pending vector and is read-only. Read data comes back one cycle after the read strobe. The request line is a purely combinational function of the stored pending and enable state. A change to the mask therefore takes effect as soon as that state changes.

Top module: `irq_aggr_top`

## Requirements
- R1: A set vector applied at a clock edge makes every pending bit it names 1 after that edge, and every other bit keeps its value.
- R2: A clear vector applied at a clock edge makes every pending bit it names 0 after that edge, and every other bit keeps its value.
- R3: When the set and clear vectors name the same bit in the same cycle, that bit ends up 1.
- R4: Pending bits 0 to 7 raise `irq_req` only while the enable bit at the same position is 1.
- R5: Any pending bit at position 8 to 15 raises `irq_req` whatever the enable register holds.
- R6: `irq_req` is 0 exactly when no enabled bit 0 to 7 is pending and no bit 8 to 15 is pending.
- R7: A write with `bus_addr`=0 loads `bus_wdata` into the enable register. A read with `bus_addr`=0 returns the enable value held before that edge.
- R8: A read with `bus_addr`=1 returns pending bits 7:0 as held before that edge. The upper pending bits are not visible at any address.
- R9: Read data and `bus_rvalid`=1 appear in the cycle after the clock edge that samples `bus_rd`. `bus_rvalid` is 0 in every other cycle.
- R10: A write with `bus_addr`=1 changes neither the pending vector nor the enable register.
- R11: A change to the enable register changes `irq_req` right after the edge that writes it, with no new set or clear event.
- R12: Reset (`rst_n`=0) clears the enable register, the pending vector, `bus_rvalid`, `bus_rdata` and `irq_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_set | input | 16 | Per-bit pending set strobes |
| src_clr | input | 16 | Per-bit pending clear strobes |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 1 | Register select: 0 enable, 1 pending low byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid when `bus_rvalid` is 1 |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| irq_req | output | 1 | Level interrupt request to the processor |

## Verification
The assertions assume that every strobe input holds a defined 0 or 1 at each sampling edge from reset onward. They also assume that the read and write strobes may arrive in the same cycle and at any address. No assumption is made about the overlap of set and clear vectors. The stimulus drives every input at the falling edge, so values are stable at every rising edge. During reset it holds all strobes at 0. A random phase deliberately mixes overlapping set and clear vectors, simultaneous reads and writes, and writes to the read-only address. The assertions must hold under all of these cases.

// File: rtl/irq_aggr_pkg.sv
`timescale 1ns/1ps
package irq_aggr_pkg;
   typedef enum logic {
      SEL_ENABLE  = 1'b0,
      SEL_PENDING = 1'b1
   } irq_reg_sel_e;
endpackage

// File: rtl/irq_pend_bank.sv
`timescale 1ns/1ps
module irq_pend_bank #(
   parameter int unsigned PEND_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PEND_W-1:0] set_i,
   input  logic [PEND_W-1:0] clr_i,
   output logic [PEND_W-1:0] pend_o
);
   generate
      if (PEND_W < 1) begin : g_bad_width
         $error("irq_pend_bank: PEND_W must be at least 1");
      end
   endgenerate

   logic [PEND_W-1:0] pend_q;

   for (genvar b = 0; b < PEND_W; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pend_q[b] <= 1'b0;
         else if (set_i[b])
            pend_q[b] <= 1'b1;
         else if (clr_i[b])
            pend_q[b] <= 1'b0;
      end
   end

   assign pend_o = pend_q;

   // R1
   set_marks_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i)));

   // R2
   clr_drops_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr_i) |=> ((pend_q & $past(clr_i) & ~$past(set_i)) == '0));

   // R3
   set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(set_i & clr_i)) |=> ((pend_q & $past(set_i & clr_i)) == $past(set_i & clr_i)));

   // R1
   untouched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & ~$past(set_i | clr_i)) == ($past(pend_q) & ~$past(set_i | clr_i))));
endmodule

// File: rtl/irq_enable_reg.sv
`timescale 1ns/1ps
module irq_enable_reg #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned MASK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [MASK_W-1:0] en_o
);
   generate
      if (MASK_W < 1 || MASK_W > DATA_W) begin : g_bad_width
         $error("irq_enable_reg: MASK_W must lie in 1..DATA_W");
      end
   endgenerate

   logic [MASK_W-1:0] en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_q <= '0;
      else if (we_i)
         en_q <= wdata_i[MASK_W-1:0];
   end

   assign en_o = en_q;

   // R7
   en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (en_o == $past(wdata_i[MASK_W-1:0])));

   // R10
   en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(en_o));
endmodule

// File: rtl/irq_line_merge.sv
`timescale 1ns/1ps
module irq_line_merge #(
   parameter int unsigned MASK_W = 8,
   parameter int unsigned NMI_W  = 8,
   localparam int unsigned PEND_W = MASK_W + NMI_W
) (
   input  logic [PEND_W-1:0] pend_i,
   input  logic [MASK_W-1:0] en_i,
   output logic              line_o
);
   logic masked_hit;
   logic nmi_hit;

   assign masked_hit = |(pend_i[MASK_W-1:0] & en_i);

   generate
      if (NMI_W > 0) begin : g_nmi
         assign nmi_hit = |pend_i[PEND_W-1:MASK_W];
      end else begin : g_no_nmi
         assign nmi_hit = 1'b0;
      end
   endgenerate

   assign line_o = masked_hit | nmi_hit;
endmodule

// File: rtl/irq_reg_port.sv
`timescale 1ns/1ps
module irq_reg_port
   import irq_aggr_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned MASK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_i,
   input  irq_reg_sel_e      sel_i,
   input  logic [MASK_W-1:0] en_i,
   input  logic [MASK_W-1:0] pend_lo_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              rvalid_o
);
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] rdata_q;
   logic              rvalid_q;

   always_comb begin
      rd_mux = '0;
      if (sel_i == SEL_ENABLE)
         rd_mux[MASK_W-1:0] = en_i;
      else
         rd_mux[MASK_W-1:0] = pend_lo_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= rd_i;
         if (rd_i)
            rdata_q <= rd_mux;
      end
   end

   assign rdata_o  = rdata_q;
   assign rvalid_o = rvalid_q;

   // R9
   rd_valid_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i |=> rvalid_o);

   // R9
   no_rd_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |=> !rvalid_o);

   // R7
   en_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && sel_i == SEL_ENABLE) |=> (rdata_o[MASK_W-1:0] == $past(en_i)));

   // R8
   pend_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && sel_i == SEL_PENDING) |=> (rdata_o[MASK_W-1:0] == $past(pend_lo_i)));
endmodule

// File: rtl/irq_aggr_top.sv
`timescale 1ns/1ps
module irq_aggr_top
   import irq_aggr_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned MASK_W = 8,
   parameter int unsigned NMI_W  = 8,
   localparam int unsigned PEND_W = MASK_W + NMI_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PEND_W-1:0] src_set,
   input  logic [PEND_W-1:0] src_clr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic              bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_rvalid,
   output logic              irq_req
);
   logic [PEND_W-1:0] pend;
   logic [MASK_W-1:0] en;
   irq_reg_sel_e      sel;
   logic              en_we;

   assign sel   = irq_reg_sel_e'(bus_addr);
   assign en_we = bus_wr && (sel == SEL_ENABLE);

   irq_pend_bank #(.PEND_W(PEND_W)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (src_set),
      .clr_i  (src_clr),
      .pend_o (pend)
   );

   irq_enable_reg #(.DATA_W(DATA_W), .MASK_W(MASK_W)) u_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (en_we),
      .wdata_i (bus_wdata),
      .en_o    (en)
   );

   irq_line_merge #(.MASK_W(MASK_W), .NMI_W(NMI_W)) u_line (
      .pend_i (pend),
      .en_i   (en),
      .line_o (irq_req)
   );

   irq_reg_port #(.DATA_W(DATA_W), .MASK_W(MASK_W)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_i      (bus_rd),
      .sel_i     (sel),
      .en_i      (en),
      .pend_lo_i (pend[MASK_W-1:0]),
      .rdata_o   (bus_rdata),
      .rvalid_o  (bus_rvalid)
   );

   // R6
   quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == '0) |-> !irq_req);

   // R4
   mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0 && pend[PEND_W-1:MASK_W] == '0) |-> !irq_req);

   // R5
   nmi_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|pend[PEND_W-1:MASK_W]) |-> irq_req);
endmodule

// File: tb/irq_aggr_top_tb.sv
`timescale 1ns/1ps
module irq_aggr_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] src_set = '0;
   logic [15:0] src_clr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic        bus_addr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        bus_rvalid;
   logic        irq_req;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference state
   logic [15:0] m_pend = '0;
   logic [7:0]  m_en = '0;
   logic [7:0]  m_rdata = '0;
   logic        m_rvalid = 1'b0;
   logic        m_raddr = 1'b0;

   always #2 clk = ~clk;

   irq_aggr_top dut_i (
      .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_clr(src_clr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq_req(irq_req)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic model_line();
      int low_hits;
      low_hits = 0;
      for (int i = 0; i < 8; i++)
         if (m_pend[i] && m_en[i]) low_hits++;
      return (low_hits > 0) || (m_pend[15:8] != 0);
   endfunction

   task automatic compare_all();
      check("R6 irq_req", int'(irq_req), int'(model_line()));
      check("R9 bus_rvalid", int'(bus_rvalid), int'(m_rvalid));
      if (m_rvalid)
         check(m_raddr ? "R8 pending read" : "R7 enable read", int'(bus_rdata), int'(m_rdata));
   endtask

   // one clock: drive at the falling edge, update the model at the rising edge,
   // compare at the next falling edge
   task automatic cyc(input logic [15:0] s, input logic [15:0] c,
                      input logic w, input logic r, input logic a, input logic [7:0] d);
      src_set = s; src_clr = c; bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      m_rvalid = r;
      if (r) begin
         m_raddr = a;
         m_rdata = a ? m_pend[7:0] : m_en;
      end
      if (w && !a) m_en = d;
      for (int i = 0; i < 16; i++) begin
         if (s[i]) m_pend[i] = 1'b1;
         else if (c[i]) m_pend[i] = 1'b0;
      end
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle();
      cyc(16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 8'h0);
   endtask

   task automatic apply_reset();
      src_set = '0; src_clr = '0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = '0;
      rst_n = 1'b0;
      m_pend = '0; m_en = '0; m_rdata = '0; m_rvalid = 1'b0;
      repeat (2) @(negedge clk);
      // R12 outputs held low during reset
      check("R12 irq_req in reset", int'(irq_req), 0);
      check("R12 bus_rvalid in reset", int'(bus_rvalid), 0);
      check("R12 bus_rdata in reset", int'(bus_rdata), 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      @(negedge clk);
      apply_reset();

      // R12 enable and pending read as zero after reset
      cyc(16'h0, 16'h0, 0, 1, 0, 8'h0);
      check("R12 enable zero", int'(bus_rdata), 0);
      cyc(16'h0, 16'h0, 0, 1, 1, 8'h0);
      check("R12 pending zero", int'(bus_rdata), 0);

      // R7 write then read back the enable register
      cyc(16'h0, 16'h0, 1, 0, 0, 8'hA5);
      cyc(16'h0, 16'h0, 0, 1, 0, 8'h0);
      check("R7 enable readback", int'(bus_rdata), 8'hA5);
      // R9 valid drops after one cycle
      idle();
      check("R9 rvalid single cycle", int'(bus_rvalid), 0);

      // R1 set bits 0,1 ; bit 0 enabled in 0xA5
      cyc(16'h0003, 16'h0, 0, 0, 0, 8'h0);
      check("R4 enabled low bit raises line", int'(irq_req), 1);
      cyc(16'h0, 16'h0, 0, 1, 1, 8'h0);
      check("R1 pending after set", int'(bus_rdata), 8'h03);

      // R2 clear bit 0 ; bit 1 stays but is masked
      cyc(16'h0, 16'h0001, 0, 0, 0, 8'h0);
      check("R4 masked bit keeps line low", int'(irq_req), 0);
      cyc(16'h0, 16'h0, 0, 1, 1, 8'h0);
      check("R2 pending after clear", int'(bus_rdata), 8'h02);

      // R11 enabling bit 1 raises the line without a set event
      cyc(16'h0, 16'h0, 1, 0, 0, 8'h02);
      check("R11 line follows enable write", int'(irq_req), 1);
      cyc(16'h0, 16'h0, 1, 0, 0, 8'h00);
      check("R11 line drops on disable", int'(irq_req), 0);

      // R5 non-maskable bit with mask all zero
      cyc(16'h0100, 16'h0002, 0, 0, 0, 8'h0);
      check("R5 upper bit ignores mask", int'(irq_req), 1);
      cyc(16'h0, 16'h0, 0, 1, 1, 8'h0);
      check("R8 upper bits hidden", int'(bus_rdata), 8'h00);
      cyc(16'h0, 16'h0100, 0, 0, 0, 8'h0);
      check("R6 line low with nothing pending", int'(irq_req), 0);

      // R3 set and clear on the same bit
      cyc(16'h8004, 16'h8004, 0, 0, 0, 8'h0);
      check("R3 set wins upper bit", int'(irq_req), 1);
      cyc(16'h0, 16'h0, 0, 1, 1, 8'h0);
      check("R3 set wins low bit", int'(bus_rdata), 8'h04);

      // R10 write to the pending address is ignored
      cyc(16'h0, 16'h0, 1, 0, 1, 8'hFF);
      cyc(16'h0, 16'h0, 0, 1, 1, 8'h0);
      check("R10 pending unchanged", int'(bus_rdata), 8'h04);
      cyc(16'h0, 16'h0, 0, 1, 0, 8'h0);
      check("R10 enable unchanged", int'(bus_rdata), 8'h00);

      // R7 read and write same cycle returns old value
      cyc(16'h0, 16'h0, 1, 1, 0, 8'h3C);
      check("R7 read returns pre-write value", int'(bus_rdata), 8'h00);
      cyc(16'h0, 16'h0, 0, 1, 0, 8'h0);
      check("R7 new value visible", int'(bus_rdata), 8'h3C);

      // R12 reset in mid-run clears state
      apply_reset();
      cyc(16'h0, 16'h0, 0, 1, 0, 8'h0);
      check("R12 enable cleared", int'(bus_rdata), 0);
      cyc(16'h0, 16'h0, 0, 1, 1, 8'h0);
      check("R12 pending cleared", int'(bus_rdata), 0);

      // mixed random traffic, compared every cycle
      for (int n = 0; n < 3000; n++) begin
         logic [15:0] s, c;
         s = 16'($urandom) & 16'($urandom) & 16'($urandom);
         c = 16'($urandom) & 16'($urandom);
         if (n % 7 == 0) s[15:8] = '0;
         cyc(s, c, 1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom));
      end

      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            fails++;
            checks++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule